// File: doc/BRIEF.md
# PWM Controller Bus Write Register Bank

This block is the write side of the parallel bus for a pulse-width modulator. It holds two 8-bit registers. The pulse-width register carries the duty command. The control register carries a stop flag, a write-once lock flag, a resolution mode, a clock-divide code and a dead-time count. A host writes a register by pulling chip-select low and pulsing the write strobe. The byte present when the strobe returns high is stored. A select line chooses the target register.

The bus pins are asynchronous to the block clock. The strobe, chip-select, select and data lines pass through a synchronizer chain. The register update happens on the clock edge that follows the detected rising edge of the synchronized strobe. After the host sets the lock flag, control writes can change only the stop flag. Only the active-low asynchronous reset can clear the lock. Reset also restores the control register to its default and clears the pulse width.

Top module: `pwm_ctrl_regs`

## Requirements
- R1: While reset is low, and after it is released, the pulse-width output is 0x00. The control register reads 0x47: lock 0, stop 1, mode 0 (8-bit), divide 00 (divide by 1), dead-time 7.
- R2: A write with chip-select low and select low loads the data byte into the pulse-width register and leaves the control register unchanged.
- R3: A write with chip-select low and select high loads the control register and leaves the pulse width unchanged. The control byte layout is bit 7 lock, bit 6 stop, bit 5 mode, bits 4:3 divide and bits 2:0 dead-time.
- R4: A strobe pulse while chip-select is high changes neither register.
- R5: The byte stored is the one present at the low-to-high strobe transition. The falling edge of the strobe stores nothing, and each strobe causes at most one update.
- R6: Once the lock flag is set, a control write updates only the stop bit (bit 6). The lock flag stays 1 even when a written byte has bit 7 clear, and the mode, divide and dead-time fields hold their values.
- R7: The pulse-width register stays writable while the lock flag is set.
- R8: Asserting reset clears the lock flag and restores the R1 values, so a later control write is accepted in full.
- R9: Strobe pulses made while reset is low have no effect after reset is released.
- R10: A register changes only on the third rising clock edge after the strobe rises (two synchronizer stages plus the edge detector). Without a qualifying write, both registers hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Active-low chip-select from the host bus |
| bus_wr_n | input | 1 | Write strobe; data is taken on its rising edge |
| bus_sel | input | 1 | Target select: 0 pulse-width register, 1 control register |
| bus_data | input | 8 | Write data byte |
| pw_value | output | 8 | Pulse-width register contents |
| ctrl_lock | output | 1 | Lock flag |
| ctrl_stop | output | 1 | Stop flag |
| ctrl_mode | output | 1 | Resolution mode, 0 = 8-bit, 1 = 7-bit |
| ctrl_div | output | 2 | Clock-divide code |
| ctrl_dead | output | 3 | Dead-time count |

## Verification
The checker enforces several properties on every clock edge. The lock flag never falls outside reset, and the locked fields stay frozen. The register that select did not choose holds its value across a write. Neither register moves without a detected strobe edge. Each strobe edge yields a pulse exactly one cycle wide, and the reset values hold while reset is low. The bench scenarios cover what needs a sequence of bus actions: that the byte at the strobe's rising edge wins over an earlier one, that strobes with chip-select high or during reset leave no trace, that the stop bit is still writable under lock, that a reset re-opens the lock, and the exact cycle in which an update appears.

// File: rtl/pwmreg_pkg.sv
package pwmreg_pkg;

    localparam int DATA_W = 8;
    localparam int DIV_W  = 2;
    localparam int DEAD_W = 3;

    // Control register layout, most significant field first.
    typedef struct packed {
        logic              lock;
        logic              stop;
        logic              mode;
        logic [DIV_W-1:0]  div;
        logic [DEAD_W-1:0] dead;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Default: unlocked, stopped, 8-bit mode, divide by 1, dead-time 7.
    localparam ctrl_t CTRL_RST = 8'b0100_0111;

    // Host bus signals as seen inside the clock domain.
    typedef struct packed {
        logic              wr_n;
        logic              cs_n;
        logic              sel;
        logic [DATA_W-1:0] data;
    } bus_t;

    localparam bus_t BUS_IDLE = '{wr_n: 1'b1, cs_n: 1'b1, sel: 1'b0, data: '0};

endpackage

// File: rtl/pwmreg_bus_sync.sv
module pwmreg_bus_sync
    import pwmreg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  bus_t bus_i,
    output bus_t bus_o
);

    typedef struct packed {
        bus_t [STAGES-1:0] stage;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.stage[0] = bus_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.stage[i] = s_q.stage[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                s_q.stage[i] <= BUS_IDLE;
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_o = s_q.stage[STAGES-1];

endmodule

// File: rtl/pwmreg_strobe_detect.sv
module pwmreg_strobe_detect
    import pwmreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bus_t              bus_i,
    output logic              pulse_o,
    output logic              sel_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic wr_prev;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.wr_prev = bus_i.wr_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.wr_prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    // Low-to-high strobe transition qualified by an active chip-select.
    assign pulse_o = bus_i.wr_n & ~s_q.wr_prev & ~bus_i.cs_n;
    assign sel_o   = bus_i.sel;
    assign data_o  = bus_i.data;

endmodule

// File: rtl/pwmreg_file.sv
module pwmreg_file
    import pwmreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pulse,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] pw_o,
    output ctrl_t             ctrl_o
);

    typedef struct packed {
        logic [DATA_W-1:0] pw;
        ctrl_t             ctrl;
    } state_t;

    state_t s_d, s_q;
    ctrl_t  wr_ctrl;

    assign wr_ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);

    always_comb begin
        s_d = s_q;
        if (wr_pulse) begin
            if (wr_sel) begin
                if (s_q.ctrl.lock) begin
                    s_d.ctrl.stop = wr_ctrl.stop;
                end else begin
                    s_d.ctrl = wr_ctrl;
                end
            end else begin
                s_d.pw = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pw   <= '0;
            s_q.ctrl <= CTRL_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign pw_o   = s_q.pw;
    assign ctrl_o = s_q.ctrl;

endmodule

// File: rtl/pwm_ctrl_regs.sv
module pwm_ctrl_regs
    import pwmreg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_wr_n,
    input  logic              bus_sel,
    input  logic [DATA_W-1:0] bus_data,
    output logic [DATA_W-1:0] pw_value,
    output logic              ctrl_lock,
    output logic              ctrl_stop,
    output logic              ctrl_mode,
    output logic [DIV_W-1:0]  ctrl_div,
    output logic [DEAD_W-1:0] ctrl_dead
);

    bus_t              bus_raw;
    bus_t              bus_sync;
    logic              wr_pulse;
    logic              wr_sel;
    logic [DATA_W-1:0] wr_data;
    ctrl_t             ctrl_q;

    assign bus_raw = '{wr_n: bus_wr_n, cs_n: bus_cs_n, sel: bus_sel, data: bus_data};

    pwmreg_bus_sync #(
        .STAGES(SYNC_STAGES)
    ) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .bus_i(bus_raw),
        .bus_o(bus_sync)
    );

    pwmreg_strobe_detect i_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .bus_i  (bus_sync),
        .pulse_o(wr_pulse),
        .sel_o  (wr_sel),
        .data_o (wr_data)
    );

    pwmreg_file i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_pulse(wr_pulse),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .pw_o    (pw_value),
        .ctrl_o  (ctrl_q)
    );

    assign ctrl_lock = ctrl_q.lock;
    assign ctrl_stop = ctrl_q.stop;
    assign ctrl_mode = ctrl_q.mode;
    assign ctrl_div  = ctrl_q.div;
    assign ctrl_dead = ctrl_q.dead;

endmodule

// File: rtl/pwm_ctrl_regs_chk.sv
module pwm_ctrl_regs_chk
    import pwmreg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_pulse,
    input logic              wr_sel,
    input logic [DATA_W-1:0] pw_value,
    input ctrl_t             ctrl_q
);

    // R1
    reset_value_chk: assert property (@(posedge clk)
        !rst_n |-> (pw_value == '0 && ctrl_q == CTRL_RST));

    // R6
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.lock |=> ctrl_q.lock);

    // R6
    locked_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.lock |=> $stable({ctrl_q.mode, ctrl_q.div, ctrl_q.dead}));

    // R2
    pw_write_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && !wr_sel) |=> $stable(ctrl_q));

    // R3
    ctrl_write_keeps_pw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && wr_sel) |=> $stable(pw_value));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pulse |=> ($stable(pw_value) && $stable(ctrl_q)));

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

endmodule

bind pwm_ctrl_regs pwm_ctrl_regs_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_pulse(wr_pulse),
    .wr_sel  (wr_sel),
    .pw_value(pw_value),
    .ctrl_q  (ctrl_q)
);

// File: tb/test_pwm_ctrl_regs.sv
module test_pwm_ctrl_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       bus_cs_n = 1'b1;
    logic       bus_wr_n = 1'b1;
    logic       bus_sel = 1'b0;
    logic [7:0] bus_data = 8'h00;
    logic [7:0] pw_value;
    logic       ctrl_lock, ctrl_stop, ctrl_mode;
    logic [1:0] ctrl_div;
    logic [2:0] ctrl_dead;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [7:0] exp_pw   = 8'h00;
    logic [7:0] exp_ctrl = 8'h47;

    typedef struct {
        string      req;
        logic [7:0] pw;
        logic [7:0] ctrl;
        int         due;
    } item_t;

    item_t q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwm_ctrl_regs i_pwm_ctrl_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_cs_n (bus_cs_n),
        .bus_wr_n (bus_wr_n),
        .bus_sel  (bus_sel),
        .bus_data (bus_data),
        .pw_value (pw_value),
        .ctrl_lock(ctrl_lock),
        .ctrl_stop(ctrl_stop),
        .ctrl_mode(ctrl_mode),
        .ctrl_div (ctrl_div),
        .ctrl_dead(ctrl_dead)
    );

    function automatic logic [7:0] act_ctrl();
        return {ctrl_lock, ctrl_stop, ctrl_mode, ctrl_div, ctrl_dead};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic model_write(input logic s, input logic [7:0] d, input logic csn);
        if (!csn) begin
            if (s) begin
                if (exp_ctrl[7]) exp_ctrl[6] = d[6];
                else             exp_ctrl    = d;
            end else begin
                exp_pw = d;
            end
        end
    endtask

    task automatic push(input string req);
        item_t it;
        it.req  = req;
        it.pw   = exp_pw;
        it.ctrl = exp_ctrl;
        it.due  = cyc + 4;
        q.push_back(it);
    endtask

    task automatic bus_write(input logic s, input logic [7:0] d, input logic csn,
                             input bit use_model, input string req);
        @(negedge clk);
        bus_cs_n = csn;
        bus_sel  = s;
        bus_data = d;
        bus_wr_n = 1'b0;
        repeat (2) @(negedge clk);
        bus_wr_n = 1'b1;
        if (use_model) begin
            model_write(s, d, csn);
            push(req);
        end
        repeat (6) @(negedge clk);
        bus_cs_n = 1'b1;
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Monitor: compares each expected item once its update is due.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() != 0 && cyc >= q[0].due) begin
                item_t it;
                it = q.pop_front();
                check(it.req, "pw", pw_value, it.pw);
                check(it.req, "ctrl", act_ctrl(), it.ctrl);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1", "pw in reset", pw_value, 8'h00);
        check("R1", "ctrl in reset", act_ctrl(), 8'h47);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "pw after reset", pw_value, 8'h00);
        check("R1", "ctrl after reset", act_ctrl(), 8'h47);

        // R2
        bus_write(1'b0, 8'hA5, 1'b0, 1'b1, "R2");
        bus_write(1'b0, 8'hFF, 1'b0, 1'b1, "R2");
        bus_write(1'b0, 8'h00, 1'b0, 1'b1, "R2");
        bus_write(1'b0, 8'h3C, 1'b0, 1'b1, "R2");
        // R3
        bus_write(1'b1, 8'h1A, 1'b0, 1'b1, "R3");
        bus_write(1'b1, 8'h3D, 1'b0, 1'b1, "R3");
        // R4
        bus_write(1'b0, 8'h33, 1'b1, 1'b1, "R4");
        bus_write(1'b1, 8'hFF, 1'b1, 1'b1, "R4");
        drain();

        // R5: data changes while the strobe is low; the late byte wins
        @(negedge clk);
        bus_cs_n = 1'b0;
        bus_sel  = 1'b0;
        bus_data = 8'h11;
        bus_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R5", "pw after falling edge only", pw_value, 8'h3C);
        bus_data = 8'h5C;
        repeat (2) @(negedge clk);
        bus_wr_n = 1'b1;
        model_write(1'b0, 8'h5C, 1'b0);
        push("R5");
        repeat (6) @(negedge clk);
        bus_cs_n = 1'b1;
        drain();

        // R10: exact update cycle after the strobe rises
        @(negedge clk);
        bus_cs_n = 1'b0;
        bus_sel  = 1'b0;
        bus_data = 8'h96;
        bus_wr_n = 1'b0;
        repeat (2) @(negedge clk);
        bus_wr_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R10", "pw after two edges", pw_value, 8'h5C);
        @(negedge clk);
        check("R10", "pw after three edges", pw_value, 8'h96);
        exp_pw = 8'h96;
        repeat (4) @(negedge clk);
        bus_cs_n = 1'b1;
        repeat (2) @(negedge clk);

        // R6: set the lock, then only stop may change
        bus_write(1'b1, 8'hA5, 1'b0, 1'b1, "R6");
        bus_write(1'b1, 8'h40, 1'b0, 1'b1, "R6");
        bus_write(1'b1, 8'h00, 1'b0, 1'b1, "R6");
        bus_write(1'b1, 8'h7F, 1'b0, 1'b1, "R6");
        // R7
        bus_write(1'b0, 8'h6B, 1'b0, 1'b1, "R7");
        drain();

        // R8: reset re-opens the lock
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_pw = 8'h00;
        exp_ctrl = 8'h47;
        repeat (2) @(negedge clk);
        check("R8", "pw after reset", pw_value, 8'h00);
        check("R8", "ctrl after reset", act_ctrl(), 8'h47);
        bus_write(1'b1, 8'h12, 1'b0, 1'b1, "R8");
        bus_write(1'b0, 8'hC3, 1'b0, 1'b1, "R8");
        drain();

        // R9: strobes while reset is low are dropped
        @(negedge clk);
        rst_n = 1'b0;
        bus_write(1'b0, 8'h99, 1'b0, 1'b0, "R9");
        bus_write(1'b1, 8'hBF, 1'b0, 1'b0, "R9");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R9", "pw after reset writes", pw_value, 8'h00);
        check("R9", "ctrl after reset writes", act_ctrl(), 8'h47);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule